// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides, for each received frame, whether its destination address should be kept. The six destination address bytes arrive one per accepted cycle, the first one flagged by a start marker. While they stream in, the block folds each byte into a running CRC-32, compares it against the station's own individual address, and notes whether the address is a group address or the broadcast address.

After the sixth byte it issues one accept/reject decision. The decision comes from one of four sources:

- a promiscuous override;
- a broadcast rule that a control bit can disable;
- an exact match against the station address;
- for group addresses, one bit of a 64-entry hash table, chosen by the top six bits of the CRC.

Setting the whole hash table to ones admits every group address. Clearing it leaves only exact matches. The decision stays on the outputs until the next start marker arrives.

Top module: `mac_dest_filter`

## Requirements
- R1: The CRC starts from 32'hFFFFFFFF at the start byte. Each byte is folded in least significant bit first using the reflected polynomial 32'hEDB88320, with no final inversion. The hash index is bits [31:26] of the CRC after the sixth byte.
- R2: Index values 32 to 63 select bit (index - 32) of `hash_hi`. Index values 0 to 31 select bit (index) of `hash_lo`. A group address that does not match exactly is accepted only when the selected bit is 1.
- R3: Exact match uses the following packing, and an address equal to it is accepted:
  - byte 0 (first received) is `station_lo[31:24]`;
  - byte 1 is `station_lo[23:16]`;
  - byte 2 is `station_lo[15:8]`;
  - byte 3 is `station_lo[7:0]`;
  - byte 4 is `station_hi[31:24]`;
  - byte 5 is `station_hi[23:16]`.
- R4: An individual address (byte 0 bit 0 = 0) that differs from the station address in any byte is rejected, whatever the hash table holds.
- R5: With `promisc` = 1 at the sixth byte, the address is accepted.
- R6: The all-ones address is accepted when `bcast_reject` = 0. It is rejected when `bcast_reject` = 1 and `promisc` = 0, even if its hash bit is set.
- R7: When both hash registers are all ones, every group address is accepted. When both are zero, a group address that is not the station address is rejected.
- R8: Timing of the decision:
  - `decision_valid` rises, and `accept` takes its value, in the cycle after the cycle that carries the sixth byte.
  - Both hold until a start marker is taken.
  - A taken start marker clears both in the next cycle.
  - `accept` is never 1 while `decision_valid` is 0.
- R9: Cycles with `byte_valid` = 0 carry no byte and leave the address untouched. Bytes received after the sixth and before the next start marker are ignored.
- R10: After reset, `decision_valid` and `accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Marks the first address byte (taken with byte_valid) |
| byte_valid | input | 1 | byte_data carries an address byte |
| byte_data | input | 8 | Destination address byte |
| station_lo | input | 32 | Station address bytes 0 to 3 |
| station_hi | input | 16 | Station address bytes 4 and 5 (upper half of the high register) |
| hash_hi | input | 32 | Group hash table, indices 32 to 63 |
| hash_lo | input | 32 | Group hash table, indices 0 to 31 |
| promisc | input | 1 | Accept every address |
| bcast_reject | input | 1 | Reject the broadcast address |
| decision_valid | output | 1 | Decision for the last address is available |
| accept | output | 1 | 1 = keep the frame |

## Verification
Two events can fall in the same cycle. A new start marker can arrive in the very cycle in which the previous decision first becomes visible, so the release of one decision and the clearing for the next coincide. The bench sends addresses back to back with no idle cycle between them. It checks three things:
- the first decision is present for exactly that one cycle with the right value;
- `decision_valid` is low in the following cycle;
- the second address still gets its own correct decision, because its CRC and match state were not polluted by the first.

// File: rtl/mac_dest_filter.sv
module mac_dest_filter #(
  parameter int ADDR_BYTES = 6,
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic [31:0] station_lo,
  input  logic [31:16] station_hi,
  input  logic [31:0] hash_hi,
  input  logic [31:0] hash_lo,
  input  logic        promisc,
  input  logic        bcast_reject,
  output logic        decision_valid,
  output logic        accept
);
  localparam int PW = $clog2(ADDR_BYTES + 1);

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++)
      r = (r >> 1) ^ ((r[0] ^ d[b]) ? POLY : 32'h0);
    return r;
  endfunction

  logic [31:0] crc_q;
  logic [PW-1:0] cnt_q;
  logic busy_q, match_q, bcast_q, group_q;

  logic [47:0] station;
  assign station = {station_lo, station_hi};

  wire          take    = byte_valid && (start || busy_q);
  wire [PW-1:0] pos     = start ? '0 : cnt_q;
  wire          last    = take && (pos == PW'(ADDR_BYTES - 1));
  wire [31:0]   crc_nx  = crc_byte(start ? 32'hFFFFFFFF : crc_q, byte_data);
  wire [7:0]    exp_b   = station[47 - 8*pos -: 8];
  wire          match_nx = (start || match_q) && (byte_data == exp_b);
  wire          bcast_nx = (start || bcast_q) && (byte_data == 8'hFF);
  wire          group_nx = start ? byte_data[0] : group_q;
  wire [5:0]    idx     = crc_nx[31:26];
  wire          hbit    = idx[5] ? hash_hi[idx[4:0]] : hash_lo[idx[4:0]];
  wire          decide  = promisc ||
                          (bcast_nx ? !bcast_reject : (match_nx || (group_nx && hbit)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= '1;
      cnt_q <= '0;
      busy_q <= 1'b0;
      match_q <= 1'b0;
      bcast_q <= 1'b0;
      group_q <= 1'b0;
      decision_valid <= 1'b0;
      accept <= 1'b0;
    end else if (take) begin
      crc_q <= crc_nx;
      cnt_q <= pos + 1'b1;
      busy_q <= !last;
      match_q <= match_nx;
      bcast_q <= bcast_nx;
      group_q <= group_nx;
      if (last) begin
        decision_valid <= 1'b1;
        accept <= decide;
      end else if (start) begin
        decision_valid <= 1'b0;
        accept <= 1'b0;
      end
    end
  end
endmodule

module mac_dest_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic byte_valid,
  input logic promisc,
  input logic last,
  input logic decision_valid,
  input logic accept
);
  p_accept_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> decision_valid);
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && byte_valid) |=> !decision_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && !(start && byte_valid)) |=> (decision_valid && $stable(accept)));
  p_sixth_sets_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> decision_valid);
  p_promisc_accepts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last && promisc) |=> accept);
endmodule

bind mac_dest_filter mac_dest_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
  .promisc(promisc), .last(last), .decision_valid(decision_valid), .accept(accept)
);

// File: tb/tb_mac_dest_filter.sv
module tb_mac_dest_filter;
  logic clk = 0, rst_n = 0, start = 0, byte_valid = 0, promisc = 0, bcast_reject = 0;
  logic [7:0] byte_data = 0;
  logic [31:0] station_lo = 32'h00112233, hash_hi = 0, hash_lo = 0;
  logic [31:16] station_hi = 16'h4455;
  logic decision_valid, accept;
  int total = 0, fails = 0;
  bit done = 0;

  localparam logic [47:0] STA = 48'h0011_2233_4455;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  always #10 clk = ~clk;

  mac_dest_filter dut (.*);

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d = a[47 - 8*i -: 8];
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c[31:26];
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start = (i == 0); byte_valid = 1; byte_data = a[47 - 8*i -: 8];
      if (i < 5)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); start = 0; byte_valid = 0; byte_data = 8'hFF;
        end
    end
    @(negedge clk); start = 0; byte_valid = 0;
  endtask

  task automatic expect_dec(input string tag, input logic exp);
    chk({tag, " valid"}, decision_valid, 1'b1);
    chk({tag, " accept"}, accept, exp);
  endtask

  task automatic set_bit(input logic [5:0] idx, input logic inv);
    hash_hi = 0; hash_lo = 0;
    if (idx[5]) hash_hi[idx[4:0]] = 1'b1; else hash_lo[idx[4:0]] = 1'b1;
    if (inv) begin hash_hi = ~hash_hi; hash_lo = ~hash_lo; end
  endtask

  task automatic t_reset;
    chk("R10 valid after reset", decision_valid, 1'b0);
    chk("R10 accept after reset", accept, 1'b0);
  endtask

  task automatic t_exact;
    hash_hi = 0; hash_lo = 0;
    send(STA, 0); expect_dec("R3 exact match", 1'b1);
    for (int i = 0; i < 6; i++) begin
      send(STA ^ (48'h02 << (8*i)), 0);
      expect_dec("R4 one byte differs", 1'b0);
    end
    hash_hi = '1; hash_lo = '1;
    send(48'h0211_2233_4456, 0); expect_dec("R4 individual ignores hash", 1'b0);
  endtask

  task automatic t_hash;
    logic [47:0] ah = 0, al = 0;
    logic fh = 0, fl = 0;
    for (int v = 0; v < 256; v++) begin
      logic [47:0] a = {40'h01_00_5E_00_00, 8'(v)};
      if (!fh && hidx(a) >= 6'd32) begin ah = a; fh = 1; end
      if (!fl && hidx(a) < 6'd32) begin al = a; fl = 1; end
    end
    set_bit(hidx(ah), 0); send(ah, 0); expect_dec("R1 R2 high half bit set", 1'b1);
    set_bit(hidx(ah), 1); send(ah, 0); expect_dec("R1 R2 high half bit clear", 1'b0);
    set_bit(hidx(al), 0); send(al, 0); expect_dec("R1 R2 low half bit set", 1'b1);
    set_bit(hidx(al), 1); send(al, 0); expect_dec("R1 R2 low half bit clear", 1'b0);
    hash_hi = '1; hash_lo = '1;
    send(ah, 0); expect_dec("R7 all ones high", 1'b1);
    send(48'h3333_0000_0001, 0); expect_dec("R7 all ones other", 1'b1);
    hash_hi = 0; hash_lo = 0;
    send(al, 0); expect_dec("R7 zero table", 1'b0);
    station_lo = 32'h0100_5E00; station_hi = 16'h00AA;
    send(48'h0100_5E00_00AA, 0); expect_dec("R7 group exact match", 1'b1);
    station_lo = 32'h00112233; station_hi = 16'h4455;
  endtask

  task automatic t_promisc;
    hash_hi = 0; hash_lo = 0; promisc = 1; bcast_reject = 1;
    send(48'h0A0B_0C0D_0E0F, 0); expect_dec("R5 promisc individual", 1'b1);
    send(BC, 0); expect_dec("R5 promisc broadcast", 1'b1);
    promisc = 0; bcast_reject = 0;
  endtask

  task automatic t_bcast;
    hash_hi = 0; hash_lo = 0;
    send(BC, 0); expect_dec("R6 broadcast accepted", 1'b1);
    bcast_reject = 1; hash_hi = '1; hash_lo = '1;
    send(BC, 0); expect_dec("R6 broadcast rejected", 1'b0);
    bcast_reject = 0;
  endtask

  task automatic t_gaps;
    hash_hi = 0; hash_lo = 0;
    send(STA, 2); expect_dec("R9 gapped exact", 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_valid = 1; start = 0; byte_data = 8'h77;
    end
    @(negedge clk); byte_valid = 0;
    expect_dec("R9 trailing bytes ignored", 1'b1);
    send(48'h0011_2233_4400, 0); expect_dec("R9 reject base", 1'b0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); byte_valid = 1; byte_data = 8'h55;
    end
    @(negedge clk); byte_valid = 0;
    expect_dec("R9 trailing bytes no change", 1'b0);
  endtask

  task automatic t_back_to_back;
    hash_hi = 0; hash_lo = 0;
    send(STA, 0);
    @(negedge clk);
    expect_dec("R8 held", 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start = (i == 0); byte_valid = 1; byte_data = STA[47 - 8*i -: 8];
      if (i == 1) chk("R8 restart clears valid", decision_valid, 1'b0);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 0) expect_dec("R8 first decision one cycle", 1'b1);
      start = (i == 0); byte_valid = 1; byte_data = 8'h0C + 8'(i);
      if (i == 1) chk("R8 cleared after coincident start", decision_valid, 1'b0);
    end
    @(negedge clk); byte_valid = 0; start = 0;
    expect_dec("R8 second decision independent", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_exact;
    t_hash;
    t_promisc;
    t_bcast;
    t_gaps;
    t_back_to_back;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule